// File: doc/BRIEF.md
# Serial FIR Engine with Rotating Accumulators

The block computes one output of an N-tap finite impulse response filter for every input sample it accepts. The filter output is the sum, over tap index k from 0 to N-1, of coefficient h[k] multiplied by the sample x[n-k], where x[n] is the sample just accepted. Past samples live in an N-deep circular history. Coefficients live in a local N-entry array that is loaded through a simple write port.

The datapath has a single multiplier and issues one history word and one coefficient per cycle. A modelled read latency, multiplier latency and adder latency sit between the issue and the accumulation. Because the adder takes three cycles, product k is added into accumulator k mod 4. This lets a new product start every cycle without waiting on the sum before it. When the last product has landed, a two-level adder tree reduces the four partial sums to one. A modelled store delay then follows, and the result appears with a one-cycle valid strobe.

Every computation follows a fixed schedule of N+26 cycles. While a computation is in progress the block takes no new sample. Arithmetic is 32-bit signed two's complement and wraps on overflow.

Top module: `tdl_fir_engine`

## Requirements
- R1: `outData` equals the sum over k = 0..N-1 of h[k]·x[n-k]. Here x[n] is the newest accepted sample, and a history slot that has never been written counts as zero.
- R2: `inReady` is high whenever no computation is running. A sample is accepted on a rising edge where `inValid` and `inReady` are both high. `inReady` is low from the cycle after acceptance until the result cycle.
- R3: `outValid` is high in the cycle that follows the (N+26)th rising edge after the acceptance edge, and it is high for exactly one cycle.
- R4: `outData` keeps the most recent result, unchanged, until the next `outValid` pulse. It is 0 after reset.
- R5: `inReady` is high again in the same cycle as `outValid`. A sample held valid in that cycle is accepted on the next edge, so back-to-back samples are accepted every N+27 cycles.
- R6: A write with `coefWr` high stores `coefData` into h[`coefAddr`] when the block is idle. A coefficient write while a computation runs is ignored.
- R7: The history keeps the last N accepted samples. A sample that is N or more acceptances old no longer contributes.
- R8: Products and sums are 32-bit signed and wrap modulo 2^32.
- R9: After reset all history words and all coefficients are zero, `outValid` is low and `inReady` is high.
- R10: `inData` presented while a computation runs changes neither the history nor any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample offered |
| inReady | output | 1 | Block can accept a sample |
| inData | input | 32 | Signed input sample |
| coefWr | input | 1 | Coefficient write strobe |
| coefAddr | input | log2(NTAPS) | Tap index to write |
| coefData | input | 32 | Signed coefficient value |
| outValid | output | 1 | One-cycle result strobe |
| outData | output | 32 | Signed filter output, held between strobes |

## Verification
The result strobe of one computation and the acceptance of the next sample can fall in the same cycle. In that cycle `inReady` returns high while `outValid` is high. The bench provokes this by holding `inValid` high, with a new sample on `inData`, through the end of a computation. It then checks three things: that the old result is correct in the strobe cycle, that the new sample is taken on the very next edge, and that the following result again arrives exactly N+26 edges later and includes the new sample in the correct history position.

// File: rtl/tdl_fir_pkg.sv
package tdl_fir_pkg;

  localparam int ACC_N  = 4;
  localparam int ACC_IW = $clog2(ACC_N);

  typedef enum logic {
    S_IDLE = 1'b0,
    S_BUSY = 1'b1
  } fir_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              accept;    // write sample into history this edge
    logic              issue;     // launch one tap fetch this edge
    logic              clrAcc;    // zero accumulator accSel
    logic              capture;   // snapshot all partial sums
    logic              coefOpen;  // coefficient writes permitted
    logic [ACC_IW-1:0] accSel;    // accumulator for issue / clear
  } fir_strobe_t;

endpackage

// File: rtl/tdl_fir_ctrl.sv
module tdl_fir_ctrl
  import tdl_fir_pkg::*;
#(
  parameter int NTAPS   = 8,
  parameter int CAP_AT  = 20,
  parameter int LATENCY = 34
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output fir_strobe_t stb
);

  localparam int CW = $clog2(LATENCY + 1);

  fir_state_t    state;
  logic [CW-1:0] cnt;
  logic          busy;

  assign busy = (state == S_BUSY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (inValid) state <= S_BUSY;
        end
        S_BUSY: begin
          if (cnt == CW'(LATENCY - 1)) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    inReady      = !busy;
    stb.accept   = !busy && inValid;
    stb.issue    = busy && (cnt < CW'(NTAPS));
    stb.clrAcc   = busy && (cnt < CW'(ACC_N));
    stb.capture  = busy && (cnt == CW'(CAP_AT));
    stb.coefOpen = !busy;
    stb.accSel   = cnt[ACC_IW-1:0];
  end

endmodule

// File: rtl/tdl_fir_datapath.sv
module tdl_fir_datapath
  import tdl_fir_pkg::*;
#(
  parameter int NTAPS   = 8,
  parameter int DW      = 32,
  parameter int MEM_LAT = 4,
  parameter int MUL_LAT = 3,
  parameter int ADD_LAT = 3,
  parameter int ST_LAT  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fir_strobe_t          stb,
  input  logic signed [DW-1:0] inData,
  input  logic                 coefWr,
  input  logic [$clog2(NTAPS)-1:0] coefAddr,
  input  logic signed [DW-1:0] coefData,
  output logic                 outValid,
  output logic signed [DW-1:0] outData
);

  localparam int AW      = $clog2(NTAPS);
  localparam int SUM_N   = ADD_LAT - 1;             // sum registers before write-back
  localparam int PAIR_AT = ADD_LAT + 1;             // tail stage doing the final add
  localparam int TAIL    = 2 * (ADD_LAT + 1) + ST_LAT + 1;

  // ---------------- storage and pointers ----------------
  logic signed [DW-1:0] hist [NTAPS];
  logic signed [DW-1:0] coef [NTAPS];
  logic [AW-1:0]        wrPtr, rdPtr, coefPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NTAPS; i++) begin
        hist[i] <= '0;
        coef[i] <= '0;
      end
      wrPtr   <= '0;
      rdPtr   <= '0;
      coefPtr <= '0;
    end else begin
      if (stb.accept) begin
        hist[wrPtr] <= inData;
        rdPtr       <= wrPtr;
        coefPtr     <= '0;
        wrPtr       <= (wrPtr == AW'(NTAPS - 1)) ? '0 : wrPtr + 1'b1;
      end else if (stb.issue) begin
        rdPtr   <= (rdPtr == '0) ? AW'(NTAPS - 1) : rdPtr - 1'b1;
        coefPtr <= coefPtr + 1'b1;
      end
      if (coefWr && stb.coefOpen && (32'(coefAddr) < NTAPS))
        coef[coefAddr] <= coefData;
    end
  end

  // ---------------- read path: issue register + MEM_LAT ----------------
  logic signed [DW-1:0] rdX [MEM_LAT+1];
  logic signed [DW-1:0] rdH [MEM_LAT+1];
  logic                 rdV [MEM_LAT+1];
  logic [ACC_IW-1:0]    rdI [MEM_LAT+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i <= MEM_LAT; i++) begin
        rdX[i] <= '0; rdH[i] <= '0; rdV[i] <= 1'b0; rdI[i] <= '0;
      end
    end else begin
      rdV[0] <= stb.issue;
      rdX[0] <= hist[rdPtr];
      rdH[0] <= coef[coefPtr];
      rdI[0] <= stb.accSel;
      for (int i = 1; i <= MEM_LAT; i++) begin
        rdV[i] <= rdV[i-1]; rdX[i] <= rdX[i-1];
        rdH[i] <= rdH[i-1]; rdI[i] <= rdI[i-1];
      end
    end
  end

  // ---------------- multiplier: operand register + MUL_LAT ----------------
  logic signed [DW-1:0] mA, mB;
  logic                 mV;
  logic [ACC_IW-1:0]    mI;
  logic signed [DW-1:0] mP  [MUL_LAT];
  logic                 mPV [MUL_LAT];
  logic [ACC_IW-1:0]    mPI [MUL_LAT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mA <= '0; mB <= '0; mV <= 1'b0; mI <= '0;
      for (int i = 0; i < MUL_LAT; i++) begin
        mP[i] <= '0; mPV[i] <= 1'b0; mPI[i] <= '0;
      end
    end else begin
      mA <= rdX[MEM_LAT];
      mB <= rdH[MEM_LAT];
      mV <= rdV[MEM_LAT];
      mI <= rdI[MEM_LAT];
      mP[0]  <= mA * mB;
      mPV[0] <= mV;
      mPI[0] <= mI;
      for (int i = 1; i < MUL_LAT; i++) begin
        mP[i] <= mP[i-1]; mPV[i] <= mPV[i-1]; mPI[i] <= mPI[i-1];
      end
    end
  end

  // ---------------- adder: operand register + ADD_LAT into rotating accs ----------------
  logic signed [DW-1:0] aIn;
  logic                 aV;
  logic [ACC_IW-1:0]    aI;
  logic signed [DW-1:0] sS [SUM_N];
  logic                 sV [SUM_N];
  logic [ACC_IW-1:0]    sI [SUM_N];
  logic signed [DW-1:0] acc [ACC_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aIn <= '0; aV <= 1'b0; aI <= '0;
      for (int i = 0; i < SUM_N; i++) begin
        sS[i] <= '0; sV[i] <= 1'b0; sI[i] <= '0;
      end
    end else begin
      aIn   <= mP[MUL_LAT-1];
      aV    <= mPV[MUL_LAT-1];
      aI    <= mPI[MUL_LAT-1];
      sS[0] <= acc[aI] + aIn;
      sV[0] <= aV;
      sI[0] <= aI;
      for (int i = 1; i < SUM_N; i++) begin
        sS[i] <= sS[i-1]; sV[i] <= sV[i-1]; sI[i] <= sI[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < ACC_N; j++) acc[j] <= '0;
    end else begin
      for (int j = 0; j < ACC_N; j++) begin
        if (sV[SUM_N-1] && (sI[SUM_N-1] == ACC_IW'(j)))
          acc[j] <= sS[SUM_N-1];
        else if (stb.clrAcc && (stb.accSel == ACC_IW'(j)))
          acc[j] <= '0;
      end
    end
  end

  // ---------------- capture, two-level reduction, store delay ----------------
  logic signed [DW-1:0] cap [ACC_N];
  logic                 capV;
  logic signed [DW-1:0] laneA [TAIL];
  logic signed [DW-1:0] laneB [TAIL];
  logic                 tV    [TAIL];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capV <= 1'b0;
      for (int j = 0; j < ACC_N; j++) cap[j] <= '0;
      for (int i = 0; i < TAIL; i++) begin
        laneA[i] <= '0; laneB[i] <= '0; tV[i] <= 1'b0;
      end
    end else begin
      capV <= stb.capture;
      if (stb.capture)
        for (int j = 0; j < ACC_N; j++) cap[j] <= acc[j];
      tV[0] <= capV;
      if (capV) begin
        laneA[0] <= cap[0] + cap[1];
        laneB[0] <= cap[2] + cap[3];
      end
      for (int i = 1; i < TAIL; i++) begin
        tV[i] <= tV[i-1];
        if (tV[i-1]) begin
          if (i == PAIR_AT) laneA[i] <= laneA[i-1] + laneB[i-1];
          else              laneA[i] <= laneA[i-1];
          laneB[i] <= laneB[i-1];
        end
      end
    end
  end

  assign outValid = tV[TAIL-1];
  assign outData  = laneA[TAIL-1];

endmodule

// File: rtl/tdl_fir_engine.sv
module tdl_fir_engine
  import tdl_fir_pkg::*;
#(
  parameter int NTAPS   = 8,
  parameter int DW      = 32,
  parameter int MEM_LAT = 4,
  parameter int MUL_LAT = 3,
  parameter int ADD_LAT = 3,
  parameter int ST_LAT  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic signed [DW-1:0]     inData,
  input  logic                     coefWr,
  input  logic [$clog2(NTAPS)-1:0] coefAddr,
  input  logic signed [DW-1:0]     coefData,
  output logic                     outValid,
  output logic signed [DW-1:0]     outData
);

  localparam int CAP_AT  = NTAPS + MEM_LAT + MUL_LAT + ADD_LAT + 2;
  localparam int TAIL    = 2 * (ADD_LAT + 1) + ST_LAT + 1;
  localparam int LATENCY = CAP_AT + 1 + TAIL;

  fir_strobe_t stb;

  tdl_fir_ctrl #(
    .NTAPS(NTAPS), .CAP_AT(CAP_AT), .LATENCY(LATENCY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .stb(stb)
  );

  tdl_fir_datapath #(
    .NTAPS(NTAPS), .DW(DW), .MEM_LAT(MEM_LAT), .MUL_LAT(MUL_LAT),
    .ADD_LAT(ADD_LAT), .ST_LAT(ST_LAT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData),
    .coefWr(coefWr), .coefAddr(coefAddr), .coefData(coefData),
    .outValid(outValid), .outData(outData)
  );

endmodule

// File: rtl/tdl_fir_engine_chk.sv
module tdl_fir_engine_chk #(
  parameter int DW  = 32,
  parameter int LAT = 34
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic          inReady,
  input logic          outValid,
  input logic [DW-1:0] outData
);

  logic [15:0] since;
  logic        run;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run   <= 1'b0;
      since <= '0;
    end else if (inValid && inReady) begin
      run   <= 1'b1;
      since <= '0;
    end else begin
      if (outValid) run <= 1'b0;
      if (run && since != 16'hFFFF) since <= since + 1'b1;
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);                                   // R3
  AST_LATENCY_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (run && since == 16'(LAT)));                  // R3
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);                        // R2
  AST_READY_AT_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inReady);                                     // R5
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));                           // R4

endmodule

bind tdl_fir_engine tdl_fir_engine_chk #(.DW(DW), .LAT(LATENCY)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outData(outData)
);

// File: tb/tdl_fir_engine_tb.sv
module tdl_fir_engine_tb;

  localparam int NTAPS = 8;
  localparam int LAT   = NTAPS + 26;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic signed [31:0] inData = '0;
  logic              coefWr = 1'b0;
  logic [2:0]        coefAddr = '0;
  logic signed [31:0] coefData = '0;
  logic              outValid;
  logic signed [31:0] outData;

  int checks = 0;
  int errors = 0;
  int wd = 0;
  int mx [NTAPS];
  int mh [NTAPS];

  always #10 clk = ~clk;

  tdl_fir_engine #(.NTAPS(NTAPS)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .coefWr(coefWr), .coefAddr(coefAddr), .coefData(coefData),
    .outValid(outValid), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expected();
    int s = 0;
    for (int k = 0; k < NTAPS; k++) s = s + mh[k] * mx[k];
    return s;
  endfunction

  function automatic void push(input int x);
    for (int k = NTAPS - 1; k > 0; k--) mx[k] = mx[k-1];
    mx[0] = x;
  endfunction

  task automatic writeCoef(input int idx, input int val);
    @(negedge clk);
    coefWr = 1'b1; coefAddr = 3'(idx); coefData = val;
    @(posedge clk);
    #1 coefWr = 1'b0;
    mh[idx] = val;
  endtask

  // counts edges from acceptance edge until outValid seen at a falling edge
  task automatic waitResult(input string req, input bit busyPoke);
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (busyPoke && cyc == 2) begin
        check(!inReady, "R2 busy refuse", int'(inReady), 0);
        inValid = 1'b1; inData = 32'sd77777;     // R10 stray sample
        coefWr = 1'b1; coefAddr = 3'd0; coefData = 32'sd999; // R6 stray write
      end
      if (busyPoke && cyc == 6) begin
        inValid = 1'b0; coefWr = 1'b0;
      end
      if (outValid || cyc > LAT + 10) break;
    end
    check(cyc == LAT, "R3 latency", cyc, LAT);
    check(outData == expected(), req, outData, expected());
  endtask

  task automatic sendOne(input int x, input string req, input bit busyPoke);
    int held;
    @(negedge clk);
    inValid = 1'b1; inData = x;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    push(x);
    #1 inValid = 1'b0;
    waitResult(req, busyPoke);
    held = outData;
    @(negedge clk);
    check(!outValid, "R3 single-cycle strobe", int'(outValid), 0);
    check(outData == held, "R4 hold result", outData, held);
  endtask

  task automatic tReset();
    check(inReady === 1'b1, "R9 reset ready", int'(inReady), 1);
    check(outValid === 1'b0, "R9 reset valid", int'(outValid), 0);
    check(outData === 32'sd0, "R4 reset data", outData, 0);
  endtask

  task automatic tImpulse();
    for (int k = 0; k < NTAPS; k++) writeCoef(k, k + 1);        // R6
    sendOne(1, "R1 impulse tap0", 1'b0);
    for (int k = 1; k < NTAPS; k++) sendOne(0, "R1 impulse response", 1'b0);
    sendOne(0, "R7 impulse aged out", 1'b0);
    check(outData == 0, "R7 history depth", outData, 0);
  endtask

  task automatic tPatterns();
    writeCoef(0, -3); writeCoef(3, 10); writeCoef(7, -7);
    for (int i = 0; i < 10; i++) sendOne(i * 13 - 40, "R1 ramp pattern", 1'b0);
    sendOne(-1, "R1 negative sample", 1'b0);
  endtask

  task automatic tBusyIgnore();
    sendOne(5, "R6 R10 result with busy pokes", 1'b1);
    sendOne(2, "R10 stray sample absent, R6 coef kept", 1'b0);
    check(mh[0] == -3, "R6 model coef", mh[0], -3);
  endtask

  task automatic tBackToBack();
    int cyc;
    @(negedge clk);
    inValid = 1'b1; inData = 300;
    @(posedge clk);
    push(300);
    #1 inData = -200;
    for (int r = 0; r < 2; r++) begin
      cyc = 0;
      forever begin
        @(posedge clk); cyc++;
        @(negedge clk);
        if (outValid || cyc > LAT + 10) break;
      end
      check(cyc == LAT, "R5 back-to-back latency", cyc, LAT);
      check(inReady == 1'b1, "R5 ready with strobe", int'(inReady), 1);
      check(outData == expected(), "R5 overlap result", outData, expected());
      if (r == 0) begin
        @(posedge clk);
        push(-200);
        #1 inValid = 1'b0;
      end
    end
  endtask

  task automatic tWrap();
    writeCoef(1, 32'sh7fffffff); writeCoef(2, 32'sh40000000);
    sendOne(32'sh7fffffff, "R8 wrap a", 1'b0);
    sendOne(3, "R8 wrap b", 1'b0);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NTAPS; k++) begin mx[k] = 0; mh[k] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    tReset();
    tImpulse();
    tPatterns();
    tBusyIgnore();
    tBackToBack();
    tWrap();
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule